// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns one virtual address into a physical address. It walks a radix page table with four levels that lives in memory. A client hands it a table root address, a 48-bit virtual address and an access kind (read, write or execute). The walker then fetches one 64-bit entry per level over a valid/ready read port, with a separate response strobe. The first three levels are directories and the fourth holds page entries. Any directory entry can end the walk early as a large page. The walker finishes with a one-cycle completion pulse that carries either a translation or a fault.

Only one walk is in progress at a time. The request side is ready only while the walker is idle. Storage of results, caching of entries and overlapping walks belong to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high exactly when no walk is in progress, and also right after reset. A request is taken when `req_valid` and `req_ready` are both high. `req_valid` is ignored while a walk runs, and the walk in progress is not disturbed.
- R2: The first read goes to `(root & ~63) + 8*vpn[35:27]`, where vpn is vaddr[47:12]. The first read is always marked cacheable (`mem_req_uncached`=0).
- R3: A later read goes to `((entry & ~63) + 8*idx)` truncated to 48 bits. Here entry is the previous 64-bit entry, and idx is vpn[26:18] for the second level, vpn[17:9] for the third and vpn[8:0] for the fourth.
- R4: Every read address is 8-byte aligned. A later read is marked uncached exactly when the previous entry has bit 2 (cacheable) clear.
- R5: An entry with bit 54 (large) set at directory level k (k=0,1,2) ends the walk. Its log2 page size is 12 + min(S, frag), where S is 27, 18 or 9 for k=0, 1, 2 and frag is entry bits [11:7]. A fourth-level entry always ends the walk with log2 size 12, whatever its bit 54 or frag.
- R6: On success, `done_paddr` = (entry[51:12] << 12) + (vaddr & (2^L-1)), where L is the log2 size. `done_vtag` is vaddr with its low L bits cleared. `done_system` is entry bit 1.
- R7: A fault ends the walk when entry bit 0 (valid) is clear, or when the access is execute (mode 2) and entry bit 4 (no-execute) is set. A fault takes priority over a large-page stop. `done_fault`=1, `done_present` = entry bit 0, and `done_kind` = mode (0 read, 1 write, 2 execute). The outputs paddr, vtag, log2 size and system flag are all zero.
- R8: A directory-level entry with a nonzero field in bits [63:59] is malformed. It ends the walk with `done_error`=1 and `done_fault`=0, takes priority over the fault checks, and leaves the other result fields zero.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays raised with the same address and uncached flag until it is accepted.
- R10: The first read is raised one cycle after a request is accepted. One cycle after a response the walker either raises the next read or pulses `done` for exactly one cycle and returns to idle. A response strobe is ignored unless a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_base | input | 48 | Table root address |
| req_vaddr | input | 48 | Virtual address to translate |
| req_mode | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 48 | Byte address of the 8-byte entry |
| mem_req_uncached | output | 1 | Read must bypass caches |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Little-endian 64-bit entry |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_present | output | 1 | Faulting entry had its valid bit set |
| done_kind | output | 2 | Access kind that faulted |
| done_error | output | 1 | Malformed directory entry |
| done_paddr | output | 52 | Translated physical address |
| done_vtag | output | 48 | Page-aligned virtual tag |
| done_log_size | output | 6 | log2 of the page size |
| done_system | output | 1 | System-page flag of the leaf |

## Verification
The read request rises one cycle after a request is accepted. After each response, either the next read or the `done` pulse is due exactly one cycle later. The bench drives every input on the falling edge and samples on the next falling edge, so each result is checked in the single cycle where it must appear, and one cycle later to confirm the pulse has dropped. During injected backpressure the held address and flag are sampled on each stalled cycle. A reference walk computed in the bench from the entry-field rules sets the expected address, the uncached flag and the final result.

// File: rtl/ptw_pkg.sv
// Shared definitions for the page table walker.
// Assumes 64-bit entries, with field positions fixed as below.
package ptw_pkg;
    localparam int ENT_W    = 64;
    localparam int B_VALID  = 0;
    localparam int B_SYSTEM = 1;
    localparam int B_CACHE  = 2;
    localparam int B_NOEXEC = 4;
    localparam int B_LARGE  = 54;
    localparam int FRAG_LO  = 7;
    localparam int FRAG_HI  = 11;
    localparam int PPN_LO   = 12;
    localparam int PPN_HI   = 51;
    localparam int BFS_LO   = 59;
    localparam int BFS_HI   = 63;

    typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2} acc_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_SEND = 2'd1, ST_WAIT = 2'd2} st_e;
endpackage

// File: rtl/ptw_index_addr.sv
// Forms the byte address of the next table entry from a table pointer,
// the level about to be read and the virtual page number.
// Assumes the VPN is at least IDX_W*LEVELS bits wide; the top level uses the highest slice.
module ptw_index_addr #(
    parameter int MEM_AW = 48,
    parameter int VPN_W  = 36,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [MEM_AW-1:0] ptr,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [VPN_W-1:0]  vpn,
    output logic [MEM_AW-1:0] addr
);
    logic [IDX_W-1:0] idx_tab [LEVELS];
    logic [IDX_W-1:0] idx;

    // Slice out one index per level, top level first.
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_tab[g] = vpn[IDX_W*(LEVELS-1-g) +: IDX_W];
    end

    // Pick the slice for the requested level and form the aligned entry address.
    always_comb begin
        idx  = idx_tab[lvl];
        addr = (ptr & ~MEM_AW'(63)) + MEM_AW'({idx, 3'b000});
    end
endmodule

// File: rtl/ptw_entry_decode.sv
// Decodes one fetched entry at a given level: stop/continue, fault,
// malformed entry, page size and the final translation.
// Assumes the last level is always a page entry; the others are directories.
module ptw_entry_decode
    import ptw_pkg::*;
#(
    parameter int VA_W       = 48,
    parameter int PA_W       = 52,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 9,
    parameter int LEVELS     = 4,
    localparam int LVL_W     = $clog2(LEVELS),
    localparam int LOG_W     = $clog2(VA_W + 1)
) (
    input  logic [ENT_W-1:0] entry,
    input  logic [LVL_W-1:0] lvl,
    input  acc_e             mode,
    input  logic [VA_W-1:0]  vaddr,
    output logic             stop,
    output logic             fault,
    output logic             present,
    output logic             error,
    output logic             next_uncached,
    output logic [LOG_W-1:0] log_size,
    output logic [PA_W-1:0]  paddr,
    output logic [VA_W-1:0]  vtag,
    output logic             system
);
    logic [LOG_W-1:0] span_tab [LEVELS];
    logic [LOG_W-1:0] span, frag, eff, log_raw;
    logic [VA_W-1:0]  off_mask;
    logic             last, leaf, ok;
    logic             unused_bits;

    // Address bits covered by one entry at each level beyond the base page.
    for (genvar g = 0; g < LEVELS; g++) begin : g_span
        assign span_tab[g] = LOG_W'(IDX_W * (LEVELS - 1 - g));
    end

    assign unused_bits = ^{entry[B_LARGE-1:PPN_HI+1], entry[BFS_LO-1:B_LARGE+1],
                           entry[FRAG_LO-1:B_NOEXEC+1], entry[B_NOEXEC-1]};

    // Classify the entry and build the result fields.
    always_comb begin
        last     = (lvl == LVL_W'(LEVELS - 1));
        span     = span_tab[lvl];
        frag     = LOG_W'(entry[FRAG_HI:FRAG_LO]);
        eff      = (frag < span) ? frag : span;
        log_raw  = LOG_W'(PAGE_SHIFT) + eff;
        off_mask = (VA_W'(1) << log_raw) - VA_W'(1);
        error    = !last && (entry[BFS_HI:BFS_LO] != '0);
        fault    = !error && (!entry[B_VALID] || (mode == ACC_EXEC && entry[B_NOEXEC]));
        leaf     = entry[B_LARGE] || last;
        stop     = error || fault || leaf;
        ok       = leaf && !error && !fault;
        present  = entry[B_VALID];
        next_uncached = !entry[B_CACHE];
        log_size = ok ? log_raw : '0;
        paddr    = ok ? ((PA_W'(entry[PPN_HI:PPN_LO]) << PAGE_SHIFT) + PA_W'(vaddr & off_mask)) : '0;
        vtag     = ok ? (vaddr & ~off_mask) : '0;
        system   = ok && entry[B_SYSTEM];
    end
endmodule

// File: rtl/pt_walker.sv
// Walks a four-level page table for one translation at a time.
// Assumes memory returns exactly one response per accepted read, never in
// the same cycle as the read is accepted.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W       = 48,
    parameter int PA_W       = 52,
    parameter int MEM_AW     = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 9,
    parameter int LEVELS     = 4,
    localparam int VPN_W     = VA_W - PAGE_SHIFT,
    localparam int LVL_W     = $clog2(LEVELS),
    localparam int LOG_W     = $clog2(VA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [MEM_AW-1:0] req_base,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_mode,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [MEM_AW-1:0] mem_req_addr,
    output logic              mem_req_uncached,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              done,
    output logic              done_fault,
    output logic              done_present,
    output logic [1:0]        done_kind,
    output logic              done_error,
    output logic [PA_W-1:0]   done_paddr,
    output logic [VA_W-1:0]   done_vtag,
    output logic [LOG_W-1:0]  done_log_size,
    output logic              done_system
);
    st_e              state;
    logic [LVL_W-1:0] lvl;
    logic [VA_W-1:0]  va_q;
    acc_e             mode_q;
    logic [MEM_AW-1:0] gen_ptr, gen_addr;
    logic [LVL_W-1:0] gen_lvl;
    logic [VPN_W-1:0] gen_vpn;

    logic             d_stop, d_fault, d_present, d_error, d_unc, d_sys;
    logic [LOG_W-1:0] d_log;
    logic [PA_W-1:0]  d_paddr;
    logic [VA_W-1:0]  d_vtag;

    // Select the address-generator inputs for the first or a later read.
    always_comb begin
        if (state == ST_IDLE) begin
            gen_ptr = req_base;
            gen_lvl = '0;
            gen_vpn = req_vaddr[VA_W-1:PAGE_SHIFT];
        end else begin
            gen_ptr = mem_rsp_data[MEM_AW-1:0];
            gen_lvl = lvl + 1'b1;
            gen_vpn = va_q[VA_W-1:PAGE_SHIFT];
        end
    end

    ptw_index_addr #(.MEM_AW(MEM_AW), .VPN_W(VPN_W), .IDX_W(IDX_W), .LEVELS(LEVELS)) u_addr (
        .ptr(gen_ptr), .lvl(gen_lvl), .vpn(gen_vpn), .addr(gen_addr)
    );

    ptw_entry_decode #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT),
                       .IDX_W(IDX_W), .LEVELS(LEVELS)) u_dec (
        .entry(mem_rsp_data), .lvl(lvl), .mode(mode_q), .vaddr(va_q),
        .stop(d_stop), .fault(d_fault), .present(d_present), .error(d_error),
        .next_uncached(d_unc), .log_size(d_log), .paddr(d_paddr), .vtag(d_vtag),
        .system(d_sys)
    );

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_SEND);

    // Walk sequencing, read address register and the completion result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state            <= ST_IDLE;
            lvl              <= '0;
            va_q             <= '0;
            mode_q           <= ACC_READ;
            mem_req_addr     <= '0;
            mem_req_uncached <= 1'b0;
            done             <= 1'b0;
            done_fault       <= 1'b0;
            done_present     <= 1'b0;
            done_kind        <= '0;
            done_error       <= 1'b0;
            done_paddr       <= '0;
            done_vtag        <= '0;
            done_log_size    <= '0;
            done_system      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q             <= req_vaddr;
                    mode_q           <= acc_e'(req_mode);
                    lvl              <= '0;
                    mem_req_addr     <= gen_addr;
                    mem_req_uncached <= 1'b0;
                    state            <= ST_SEND;
                end
                ST_SEND: if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (d_stop) begin
                        done          <= 1'b1;
                        done_fault    <= d_fault;
                        done_present  <= d_fault && d_present;
                        done_kind     <= d_fault ? 2'(mode_q) : 2'd0;
                        done_error    <= d_error;
                        done_paddr    <= d_paddr;
                        done_vtag     <= d_vtag;
                        done_log_size <= d_log;
                        done_system   <= d_sys;
                        state         <= ST_IDLE;
                    end else begin
                        mem_req_addr     <= gen_addr;
                        mem_req_uncached <= d_unc;
                        lvl              <= lvl + 1'b1;
                        state            <= ST_SEND;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_checker.sv
// Protocol and result checks for pt_walker, attached by bind.
module ptw_checker #(
    parameter int MEM_AW     = 48,
    parameter int PA_W       = 52,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 9,
    parameter int LEVELS     = 4,
    parameter int LOG_W      = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [MEM_AW-1:0] mem_req_addr,
    input logic              mem_req_uncached,
    input logic              mem_rsp_valid,
    input logic              done,
    input logic              done_fault,
    input logic              done_error,
    input logic [PA_W-1:0]   done_paddr,
    input logic [LOG_W-1:0]  done_log_size
);
    localparam int MAX_LOG = PAGE_SHIFT + IDX_W * (LEVELS - 1);

    AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !mem_req_valid); // R1
    AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> mem_req_addr[2:0] == 3'b000); // R4
    AST_HOLD_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_uncached)); // R9
    AST_LEAF_SIZE: assert property (@(posedge clk) disable iff (!rst_n) done && !done_fault && !done_error |-> done_log_size >= LOG_W'(PAGE_SHIFT) && done_log_size <= LOG_W'(MAX_LOG)); // R5
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) done && done_fault |-> done_paddr == '0 && done_log_size == '0); // R7
    AST_ERROR_ONLY: assert property (@(posedge clk) disable iff (!rst_n) done && done_error |-> !done_fault && done_paddr == '0); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(mem_rsp_valid) && req_ready); // R10
endmodule

bind pt_walker ptw_checker #(
    .MEM_AW(MEM_AW), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT),
    .IDX_W(IDX_W), .LEVELS(LEVELS), .LOG_W(LOG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_uncached(mem_req_uncached),
    .mem_rsp_valid(mem_rsp_valid), .done(done), .done_fault(done_fault),
    .done_error(done_error), .done_paddr(done_paddr), .done_log_size(done_log_size)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_base = '0;
    logic [47:0] req_vaddr = '0;
    logic [1:0]  req_mode = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [47:0] mem_req_addr;
    logic        mem_req_uncached;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done, done_fault, done_present, done_error, done_system;
    logic [1:0]  done_kind;
    logic [51:0] done_paddr;
    logic [47:0] done_vtag;
    logic [5:0]  done_log_size;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_vaddr(req_vaddr), .req_mode(req_mode),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_uncached(mem_req_uncached),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_fault(done_fault), .done_present(done_present),
        .done_kind(done_kind), .done_error(done_error), .done_paddr(done_paddr),
        .done_vtag(done_vtag), .done_log_size(done_log_size), .done_system(done_system)
    );

    typedef struct packed {
        logic [47:0]      base;
        logic [47:0]      va;
        logic [1:0]       mode;
        logic [3:0][63:0] ent;
        logic [1:0]       bp;
        logic             noise;
    } vec_t;

    localparam logic [63:0] D0 = 64'h0000_0000_0010_0005;
    localparam logic [63:0] D1 = 64'h0000_0000_0020_0005;
    localparam logic [63:0] D2 = 64'h0000_0000_0030_0005;
    localparam logic [47:0] VA = 48'h1234_5678_9ABC;
    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{48'h0000_0040_0000, VA, 2'd0, {64'h0000_00AB_CDEF_1003, 64'h0000_0000_0030_0007, 64'h0000_0000_0020_0001, D0}, 2'd0, 1'b0},
        '{48'h0000_0040_0040, 48'h7FFF_FFFF_FFFF, 2'd0, {64'h0, 64'h0, 64'h0, 64'h0040_0000_8000_0F01}, 2'd0, 1'b0},
        '{48'h0000_0123_4000, VA, 2'd1, {64'h0, 64'h0, 64'h0040_0012_3450_0283, D0}, 2'd1, 1'b1},
        '{48'h0000_0000_1000, 48'hABCD_EF01_2345, 2'd2, {64'h0, 64'h0040_0000_0777_7A05, D1, D0}, 2'd0, 1'b0},
        '{48'h0000_0040_0000, VA, 2'd1, {64'h0, 64'h0, 64'h0000_0000_0050_0004, D0}, 2'd0, 1'b0},
        '{48'h0000_0040_0000, VA, 2'd2, {64'h0000_0000_0999_9011, D2, D1, D0}, 2'd0, 1'b0},
        '{48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 2'd2, {64'h0000_0000_0ABC_D007, 64'h0000_0000_0030_0003, 64'h0000_0000_0020_0001, 64'h000F_FFFF_FFFF_FFC5}, 2'd3, 1'b0},
        '{48'h0000_0040_0000, VA, 2'd0, {64'h0, 64'h0800_0000_0030_0005, D1, D0}, 2'd0, 1'b0},
        '{48'h0000_0040_0000, VA, 2'd0, {64'h0000_0000_0999_9011, D2, D1, D0}, 2'd0, 1'b0},
        '{48'h0000_0040_0000, VA, 2'd0, {64'h0040_0000_1234_5F81, D2, D1, D0}, 2'd1, 1'b0},
        '{48'h0000_0040_0000, VA, 2'd2, {64'h0, 64'h0, 64'h0, 64'h0040_0000_8000_0F11}, 2'd0, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives one walk and checks every read and the result against a bench-side model.
    task automatic run_vec(input vec_t v, input int id);
        logic [63:0] ptr = {16'h0, v.base};
        logic        unc = 1'b0;
        logic [35:0] vpn = v.va[47:12];
        bit          fin = 0;
        int          lvl = 0;
        @(negedge clk);
        req_valid = 1'b1; req_base = v.base; req_vaddr = v.va; req_mode = v.mode;
        @(negedge clk);
        if (v.noise) begin req_vaddr = ~v.va; req_mode = 2'd2; end
        else req_valid = 1'b0;
        while (!fin) begin
            logic [8:0]  idx = vpn[9*(3-lvl) +: 9];
            logic [47:0] ea = 48'(((ptr >> 6) << 6) + (64'(idx) << 3));
            logic [63:0] e;
            chk($sformatf("R10 vec%0d lvl%0d read raised", id, lvl), 64'(mem_req_valid), 64'd1);
            chk($sformatf("R1 vec%0d busy not ready", id), 64'(req_ready), 64'd0);
            chk($sformatf("%s vec%0d lvl%0d address", (lvl == 0) ? "R2" : "R3", id, lvl), 64'(mem_req_addr), 64'(ea));
            chk($sformatf("R4 vec%0d lvl%0d uncached", id, lvl), 64'(mem_req_uncached), 64'(unc));
            for (int b = 0; b < int'(v.bp); b++) begin
                mem_req_ready = 1'b0;
                @(negedge clk);
                chk($sformatf("R9 vec%0d held valid", id), 64'(mem_req_valid), 64'd1);
                chk($sformatf("R9 vec%0d held address", id), 64'(mem_req_addr), 64'(ea));
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            e = v.ent[lvl];
            mem_rsp_valid = 1'b1; mem_rsp_data = e;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if ((lvl < 3) && (e[63:59] != 0)) begin
                fin = 1;
                chk($sformatf("R8 vec%0d done", id), 64'(done), 64'd1);
                chk($sformatf("R8 vec%0d error", id), 64'(done_error), 64'd1);
                chk($sformatf("R8 vec%0d no fault", id), 64'(done_fault), 64'd0);
                chk($sformatf("R8 vec%0d paddr zero", id), 64'(done_paddr), 64'd0);
            end else if (!e[0] || (v.mode == 2'd2 && e[4])) begin
                fin = 1;
                chk($sformatf("R7 vec%0d done", id), 64'(done), 64'd1);
                chk($sformatf("R7 vec%0d fault", id), 64'(done_fault), 64'd1);
                chk($sformatf("R7 vec%0d present", id), 64'(done_present), 64'(e[0]));
                chk($sformatf("R7 vec%0d kind", id), 64'(done_kind), 64'(v.mode));
                chk($sformatf("R7 vec%0d size zero", id), 64'(done_log_size), 64'd0);
            end else if (e[54] || lvl == 3) begin
                int span = 9 * (3 - lvl);
                int lg = 12 + ((int'(e[11:7]) < span) ? int'(e[11:7]) : span);
                logic [47:0] m = (48'd1 << lg) - 48'd1;
                logic [51:0] pa = {e[51:12], 12'h0} + 52'(v.va & m);
                fin = 1;
                chk($sformatf("R10 vec%0d done", id), 64'(done), 64'd1);
                chk($sformatf("R5 vec%0d log size", id), 64'(done_log_size), 64'(lg));
                chk($sformatf("R6 vec%0d paddr", id), 64'(done_paddr), 64'(pa));
                chk($sformatf("R6 vec%0d vtag", id), 64'(done_vtag), 64'(v.va & ~m));
                chk($sformatf("R6 vec%0d system", id), 64'(done_system), 64'(e[1]));
                chk($sformatf("R7 vec%0d no fault", id), 64'(done_fault), 64'd0);
            end else begin
                ptr = e; unc = !e[2]; lvl++;
                chk($sformatf("R10 vec%0d no early done", id), 64'(done), 64'd0);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk($sformatf("R10 vec%0d done pulse ends", id), 64'(done), 64'd0);
        chk($sformatf("R1 vec%0d idle after", id), 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset ready", 64'(req_ready), 64'd1);
        chk("R1 reset no read", 64'(mem_req_valid), 64'd0);
        chk("R10 reset no done", 64'(done), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // Stray response while idle must not produce a completion.
        mem_rsp_valid = 1'b1; mem_rsp_data = 64'h0040_0000_8000_0F01;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        @(negedge clk);
        chk("R10 stray response ignored", 64'(done), 64'd0);
        chk("R10 stray response no read", 64'(mem_req_valid), 64'd0);

        // Reset in the middle of a walk returns to idle.
        req_valid = 1'b1; req_base = 48'h40_0000; req_vaddr = VA; req_mode = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 read after accept", 64'(mem_req_valid), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid-walk reset ready", 64'(req_ready), 64'd1);
        chk("R1 mid-walk reset no read", 64'(mem_req_valid), 64'd0);

        // A fresh walk after the reset still behaves.
        run_vec(VEC[0], 100);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule